// File: doc/BRIEF.md
# UART Channel Interrupt Enable and Request Combiner

This block sits beside one UART channel and decides when that channel raises its interrupt line. The host writes an 8-bit enable register. Each bit either masks or admits one interrupt source. One bit is not an interrupt source: it is a sleep request that is only passed on to the power logic outside this block. The host can read the register back at any time.

There are two kinds of source. Level sources come from the receiver, the transmitter and the modem-status logic: data ready, holding register empty, a line error, and any of four modem-change flags. Event sources are a received Xoff flow-control character and a low-to-high transition on the CTS or RTS pin. Each event source sets a pending flag that stays set until the host reads the status register. The CTS and RTS pins are asynchronous, so they are synchronised before the edge detector sees them. The interrupt output is a registered OR of every source whose enable bit is set.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable register reads 8'h00, `sleep_en` is 0 and `irq` is 0. All pending flags are clear.
- R2: A cycle with `host_wr` high loads `host_wdata` into the enable register, and `ier_rd` shows the new value one clock later. Without `host_wr`, the register holds its value. `sleep_en` always equals enable bit 4.
- R3: Enable bit 0 admits `rx_ready`, bit 1 admits `thr_empty` and bit 2 admits `line_err`. Each of these is a level source.
- R4: Enable bit 3 admits the modem source. This source is active while any bit of `msr_delta[3:0]` is 1.
- R5: A one-cycle pulse on `xoff_rcvd` sets the Xoff pending flag. Enable bit 5 admits that flag.
- R6: A 0-to-1 transition on `cts_pin` sets the CTS pending flag, and enable bit 7 admits it. A 0-to-1 transition on `rts_pin` sets the RTS pending flag, and enable bit 6 admits it. A falling edge or a steady level on either pin sets nothing. Each pin goes through a two-flop synchroniser before edge detection.
- R7: A pending flag stays set until a cycle with `host_stat_rd` high clears it. If an event for that flag arrives in the same cycle as the clear, the flag stays set.
- R8: Clearing an enable bit masks its source but keeps the pending flag. Setting the bit again raises `irq` with no new event.
- R9: `irq` is registered. It is 1 one clock after a cycle in which any source is active and its enable bit is set. Bit 4 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Enable register write strobe |
| host_wdata | input | 8 | Enable register write data |
| host_stat_rd | input | 1 | Status read strobe; clears pending event flags |
| ier_rd | output | 8 | Enable register readback |
| sleep_en | output | 1 | Sleep request (enable bit 4) |
| rx_ready | input | 1 | Receiver data ready (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| line_err | input | 1 | Receiver line status condition (level) |
| msr_delta | input | 4 | Modem status change flags (level) |
| xoff_rcvd | input | 1 | One-cycle pulse: Xoff character received |
| cts_pin | input | 1 | Raw asynchronous CTS pin |
| rts_pin | input | 1 | Raw asynchronous RTS pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed delay from its stimulus:
- A register write appears on `ier_rd` and `sleep_en` one edge after the write is sampled.
- A level source, or a change in an enable bit, reaches `irq` one edge later.
- An Xoff pulse reaches `irq` two edges later.
- A pin level captured at edge e reaches `irq` three edges later, after the two synchroniser stages and the pending flag.

The bench reference model keeps a short history of each pin's samples and applies these delays on its own. It is updated on every rising edge, and all outputs are compared on the following falling edge. Directed phases cover the corner cases: a status read in the same cycle as an event, masking and unmasking while a flag is pending, and a falling pin edge. A random phase then mixes every input.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W     = 8;
  localparam int MSR_W     = 4;
  localparam int N_EVT     = 3;
  // enable bit positions
  localparam int B_RX      = 0;
  localparam int B_THR     = 1;
  localparam int B_LINE    = 2;
  localparam int B_MODEM   = 3;
  localparam int B_SLEEP   = 4;
  localparam int B_XOFF    = 5;
  localparam int B_RTS     = 6;
  localparam int B_CTS     = 7;
  // pending flag positions
  localparam int E_XOFF    = 0;
  localparam int E_RTS     = 1;
  localparam int E_CTS     = 2;
endpackage

// File: rtl/uart_irq_enreg.sv
module uart_irq_enreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata;
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr |=> q == $past(wdata));
  a_r2_holds: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/uart_irq_rise.sv
module uart_irq_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b0;
    else     sync_q[0] <= pin;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= 1'b0;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         pend[i] <= 1'b0;
      else if (evt[i]) pend[i] <= 1'b1;
      else if (clr)    pend[i] <= 1'b0;
    end

    a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> pend[i]);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
      (clr && !evt[i]) |=> !pend[i]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (!clr && !evt[i]) |=> pend[i] == $past(pend[i]));
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_wr,
  input  logic [IER_W-1:0] host_wdata,
  input  logic             host_stat_rd,
  output logic [IER_W-1:0] ier_rd,
  output logic             sleep_en,
  input  logic             rx_ready,
  input  logic             thr_empty,
  input  logic             line_err,
  input  logic [MSR_W-1:0] msr_delta,
  input  logic             xoff_rcvd,
  input  logic             cts_pin,
  input  logic             rts_pin,
  output logic             irq
);
  logic [IER_W-1:0] ier_q;
  logic [N_EVT-1:0] evt;
  logic [N_EVT-1:0] pend;
  logic [IER_W-1:0] src;
  logic             cts_rise, rts_rise;

  uart_irq_enreg #(.W(IER_W)) i_enreg (
    .clk(clk), .rst(rst), .wr(host_wr), .wdata(host_wdata), .q(ier_q)
  );

  uart_irq_rise #(.STAGES(SYNC_STAGES)) i_cts_rise (
    .clk(clk), .rst(rst), .pin(cts_pin), .rise(cts_rise)
  );
  uart_irq_rise #(.STAGES(SYNC_STAGES)) i_rts_rise (
    .clk(clk), .rst(rst), .pin(rts_pin), .rise(rts_rise)
  );

  always_comb begin
    evt         = '0;
    evt[E_XOFF] = xoff_rcvd;
    evt[E_RTS]  = rts_rise;
    evt[E_CTS]  = cts_rise;
  end

  uart_irq_sticky #(.N(N_EVT)) i_sticky (
    .clk(clk), .rst(rst), .evt(evt), .clr(host_stat_rd), .pend(pend)
  );

  always_comb begin
    src          = '0;
    src[B_RX]    = rx_ready;
    src[B_THR]   = thr_empty;
    src[B_LINE]  = line_err;
    src[B_MODEM] = |msr_delta;
    src[B_XOFF]  = pend[E_XOFF];
    src[B_RTS]   = pend[E_RTS];
    src[B_CTS]   = pend[E_CTS];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(src & ier_q);
  end

  assign ier_rd   = ier_q;
  assign sleep_en = ier_q[B_SLEEP];

  a_r9_sleep_no_irq: assert property (@(posedge clk) disable iff (rst)
    (ier_q == IER_W'(1 << B_SLEEP)) |=> !irq);
  a_r9_all_masked: assert property (@(posedge clk) disable iff (rst)
    (ier_q == '0) |=> !irq);
  a_r1_irq_reset: assert property (@(posedge clk)
    rst |=> !irq);
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 0, host_stat_rd = 0;
  logic [7:0] host_wdata = 0;
  logic       rx_ready = 0, thr_empty = 0, line_err = 0, xoff_rcvd = 0;
  logic [3:0] msr_delta = 0;
  logic       cts_pin = 0, rts_pin = 0;
  logic [7:0] ier_rd;
  logic       sleep_en, irq;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  uart_irq_ctrl i_uart_irq_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_stat_rd(host_stat_rd), .ier_rd(ier_rd), .sleep_en(sleep_en),
    .rx_ready(rx_ready), .thr_empty(thr_empty), .line_err(line_err),
    .msr_delta(msr_delta), .xoff_rcvd(xoff_rcvd), .cts_pin(cts_pin),
    .rts_pin(rts_pin), .irq(irq)
  );

  // reference model
  logic [7:0] m_ier = 0;
  logic       m_irq = 0;
  bit         m_px = 0, m_pr = 0, m_pc = 0;
  bit   [2:0] hc = 0, hr = 0; // pin samples, [0] newest

  always @(posedge clk) begin
    if (rst) begin
      m_ier = 0; m_irq = 0; m_px = 0; m_pr = 0; m_pc = 0; hc = 0; hr = 0;
    end else begin
      bit [7:0] s;
      bit c_ev, r_ev;
      s = {m_pc, m_pr, m_px, 1'b0, (msr_delta != 0), line_err, thr_empty, rx_ready};
      m_irq = (s & m_ier) != 0;
      c_ev = hc[1] && !hc[2];
      r_ev = hr[1] && !hr[2];
      m_pc = c_ev ? 1 : (host_stat_rd ? 0 : m_pc);
      m_pr = r_ev ? 1 : (host_stat_rd ? 0 : m_pr);
      m_px = xoff_rcvd ? 1 : (host_stat_rd ? 0 : m_px);
      if (host_wr) m_ier = host_wdata;
      hc = {hc[1:0], cts_pin};
      hr = {hr[1:0], rts_pin};
    end
  end

  always @(negedge clk) if (!done) begin
    cycles++;
    compared++;
    if (irq !== m_irq) begin
      mismatched++;
      $display("FAIL %s irq: actual %b expected %b (cycle %0d)", cur_req, irq, m_irq, cycles);
    end
    compared++;
    if (ier_rd !== m_ier) begin
      mismatched++;
      $display("FAIL R2 ier_rd: actual %h expected %h (cycle %0d)", ier_rd, m_ier, cycles);
    end
    compared++;
    if (sleep_en !== m_ier[4]) begin
      mismatched++;
      $display("FAIL R2 sleep_en: actual %b expected %b (cycle %0d)", sleep_en, m_ier[4], cycles);
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ier(logic [7:0] v);
    host_wr = 1; host_wdata = v; tick(); host_wr = 0;
  endtask

  task automatic stat_rd();
    host_stat_rd = 1; tick(); host_stat_rd = 0;
  endtask

  initial begin
    tick(3);
    cur_req = "R1";          // reset state checked during and after reset
    rst = 0; tick(2);

    cur_req = "R3";          // level sources, bits 0..2
    rx_ready = 1; tick(2);   // masked
    wr_ier(8'h01); tick(2);
    rx_ready = 0; thr_empty = 1; tick(2);
    wr_ier(8'h02); tick(2);
    thr_empty = 0; line_err = 1; tick(2);
    wr_ier(8'h04); tick(2);
    line_err = 0; tick(2);

    cur_req = "R4";          // modem change, bit 3
    wr_ier(8'h08);
    for (int b = 0; b < 4; b++) begin
      msr_delta = 4'(1 << b); tick(2); msr_delta = 0; tick(2);
    end

    cur_req = "R9";          // sleep bit alone never requests
    wr_ier(8'h10);
    rx_ready = 1; thr_empty = 1; line_err = 1; msr_delta = 4'hF; tick(3);
    rx_ready = 0; thr_empty = 0; line_err = 0; msr_delta = 0;

    cur_req = "R5";          // Xoff pending
    wr_ier(8'h20);
    xoff_rcvd = 1; tick(); xoff_rcvd = 0; tick(4);
    cur_req = "R7";
    stat_rd(); tick(2);
    xoff_rcvd = 1; host_stat_rd = 1; tick(); xoff_rcvd = 0; host_stat_rd = 0; tick(3);

    cur_req = "R8";          // mask keeps pending
    wr_ier(8'h00); tick(3);
    wr_ier(8'h20); tick(2);
    stat_rd(); tick(2);

    cur_req = "R6";          // pin edges
    wr_ier(8'hC0);
    cts_pin = 1; tick(6);
    stat_rd(); tick(2);
    cts_pin = 0; tick(6);    // falling edge: nothing
    rts_pin = 1; tick(6);
    stat_rd(); rts_pin = 0; tick(6);
    cts_pin = 1; rts_pin = 1; tick(2);
    host_stat_rd = 1; tick(); host_stat_rd = 0; tick(5); // clear coincides with edge
    stat_rd(); cts_pin = 0; rts_pin = 0; tick(4);

    cur_req = "R2";
    wr_ier(8'hA5); tick(); wr_ier(8'h5A); tick(2);

    cur_req = "R9";          // random mix
    for (int i = 0; i < 3000; i++) begin
      host_wr      = ($urandom_range(0, 15) == 0);
      host_wdata   = 8'($urandom);
      host_stat_rd = ($urandom_range(0, 7) == 0);
      rx_ready     = ($urandom_range(0, 3) == 0);
      thr_empty    = ($urandom_range(0, 3) == 0);
      line_err     = ($urandom_range(0, 7) == 0);
      msr_delta    = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      xoff_rcvd    = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 5) == 0) cts_pin = ~cts_pin;
      if ($urandom_range(0, 5) == 0) rts_pin = ~rts_pin;
      if (i == 1500) rst = 1;
      if (i == 1503) rst = 0;
      tick();
    end
    host_wr = 0; host_stat_rd = 0; xoff_rcvd = 0;
    tick(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule